// File: doc/BRIEF.md
# 1-Wire ROM Select Sequencer

This block is the master-side sequencer for the device-select phase of a 1-Wire transaction. It runs once the bus reset and presence exchange are over. A one-cycle start pulse latches a 64-bit device identifier and a flag that picks either a plain select or an overdrive select. The sequencer then streams a command byte followed by the identifier to a lower bit-slot layer, one write slot per bit. It raises a done pulse when the last slot has been taken.

Bits leave through a valid/ready stream. `slot_valid` marks an outstanding write-slot request and `slot_bit` carries its value. The slot layer takes the bit on a clock edge where `slot_ready` is also high. The slot layer may hold `slot_ready` low for as long as it needs, and the request waits with its bit unchanged; this is the only back-pressure. The `speed_od` output tells the slot-timing layer which slot timing to use. Every slot of a select, including an overdrive select, runs at standard speed. An overdrive select moves the bus to overdrive only once its final slot is accepted. The bus stays in overdrive until a bus reset or a block reset.

Top module: `owsel_rom_select`

## Requirements
- R1: The first 8 accepted slots carry the command byte, least significant bit first. The byte is 55h when `overdrive` was low at start and 69h when it was high.
- R2: Accepted slots 9 to 72 carry `rom_id` bit 0 up to bit 63, in that order. A select has exactly 72 accepted slots.
- R3: `speed_od` does not change while `busy` is high, so every slot of a select, overdrive or plain, runs at the speed in force before it started.
- R4: While `slot_valid` is high and `slot_ready` is low, `slot_valid` stays high and `slot_bit` keeps its value on the next cycle. One bit is transferred per cycle in which both are high.
- R5: A start pulse while `busy` is high is ignored. The running select keeps its identifier and command byte, and no extra slots are produced.
- R6: `done` is high for exactly one cycle, the cycle after the edge that accepts the 72nd slot. In that same cycle `busy` and `slot_valid` are low.
- R7: After an overdrive select, `speed_od` is 1 from the done cycle onward and stays 1 through later selects until a reset.
- R8: A plain select never changes `speed_od`.
- R9: After reset, and one cycle after `bus_reset` is sampled high, `speed_od`, `slot_valid`, `busy` and `done` are 0. A select in progress when `bus_reset` is sampled is abandoned and never raises `done`. Asserting `rst_n` low clears `speed_od` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset seen: abort the select and return to standard speed |
| start | input | 1 | One-cycle request to begin a select |
| overdrive | input | 1 | At start: 1 selects overdrive (69h), 0 selects plain (55h) |
| rom_id | input | 64 | Device identifier, latched at start |
| slot_valid | output | 1 | Write-slot request outstanding |
| slot_ready | input | 1 | Slot layer accepts the request on this edge |
| slot_bit | output | 1 | Value to write in the requested slot |
| speed_od | output | 1 | 1 = overdrive slot timing, 0 = standard |
| busy | output | 1 | Select in progress |
| done | output | 1 | One-cycle pulse at the end of a select |

## Verification
A start sampled at an edge makes `busy` and `slot_valid` high for the following cycle. Each accepted slot presents the next bit one cycle after the accepting edge. `done`, and with it the overdrive switch, appears one cycle after the 72nd accepting edge, and `bus_reset` takes effect one cycle after it is sampled. The bench drives inputs and samples outputs on the falling edge. It logs a slot only when it saw `slot_valid` and drove `slot_ready` high at that falling edge, and it checks the done and speed results at the very next falling edge after the last slot. The sweep covers several identifiers, both command codes and three back-pressure patterns on `slot_ready`.

// File: rtl/owsel_pkg.sv
package owsel_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_PLAIN = 8'h55;
  localparam logic [CMD_W-1:0] CMD_OVERDRIVE = 8'h69;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } owsel_state_e;
endpackage

// File: rtl/owsel_frame.sv
module owsel_frame #(
  parameter int W = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         lsb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift) begin
      sh_q <= {1'b0, sh_q[W-1:1]};
    end
  end

  assign lsb = sh_q[0];
endmodule

// File: rtl/owsel_ctrl.sv
module owsel_ctrl
  import owsel_pkg::*;
#(
  parameter int TOTAL = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  input  logic hs,
  output logic load,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  owsel_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign busy   = (state_q == ST_SEND);
  assign load   = (state_q == ST_IDLE) && start && !abort;
  assign finish = busy && hs && (cnt_q == LAST) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start) begin
              state_q <= ST_SEND;
              cnt_q   <= '0;
            end
          end
          ST_SEND: begin
            if (hs) begin
              if (cnt_q == LAST) begin
                state_q <= ST_IDLE;
                done    <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/owsel_speed.sv
module owsel_speed (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic od
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od <= 1'b0;
    end else if (clr) begin
      od <= 1'b0;
    end else if (set) begin
      od <= 1'b1;
    end
  end
endmodule

// File: rtl/owsel_rom_select.sv
module owsel_rom_select
  import owsel_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            start,
  input  logic            overdrive,
  input  logic [ID_W-1:0] rom_id,
  output logic            slot_valid,
  input  logic            slot_ready,
  output logic            slot_bit,
  output logic            speed_od,
  output logic            busy,
  output logic            done
);
  localparam int TOTAL = CMD_W + ID_W;

  logic load, finish, hs, od_q;
  logic [CMD_W-1:0] cmd;

  assign cmd        = overdrive ? CMD_OVERDRIVE : CMD_PLAIN;
  assign slot_valid = busy;
  assign hs         = slot_valid && slot_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= 1'b0;
    end else if (load) begin
      od_q <= overdrive;
    end
  end

  owsel_ctrl #(.TOTAL(TOTAL)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (bus_reset),
    .start  (start),
    .hs     (hs),
    .load   (load),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  owsel_frame #(.W(TOTAL)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val ({rom_id, cmd}),
    .shift    (hs),
    .lsb      (slot_bit)
  );

  owsel_speed u_speed (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bus_reset),
    .set   (finish && od_q),
    .od    (speed_od)
  );
endmodule

// File: rtl/owsel_checker.sv
module owsel_checker #(
  parameter int TOTAL = 72
) (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic slot_valid,
  input logic slot_ready,
  input logic slot_bit,
  input logic speed_od,
  input logic busy,
  input logic done
);
  localparam int KW = $clog2(TOTAL + 1);
  logic [KW-1:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= '0;
    else if (bus_reset) taken_q <= '0;
    else if (slot_valid && slot_ready) taken_q <= taken_q + 1'b1;
    else if (done) taken_q <= '0;
  end

  a_r2_slot_count: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    done |-> (taken_q == KW'(TOTAL)));

  a_r3_speed_steady: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    busy |-> $stable(speed_od));

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_bit)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !slot_valid));

  a_r7_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speed_od) |-> done);

  a_r9_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!speed_od && !slot_valid && !busy && !done));
endmodule

bind owsel_rom_select owsel_checker #(.TOTAL(TOTAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_reset  (bus_reset),
  .slot_valid (slot_valid),
  .slot_ready (slot_ready),
  .slot_bit   (slot_bit),
  .speed_od   (speed_od),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_owsel_rom_select.sv
`timescale 1ns/1ps
module tb_owsel_rom_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic start = 1'b0;
  logic overdrive = 1'b0;
  logic [63:0] rom_id = '0;
  logic slot_ready = 1'b0;
  logic slot_valid, slot_bit, speed_od, busy, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic spd_model = 1'b0;

  always #2.5 clk = ~clk;

  owsel_rom_select dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .start(start),
    .overdrive(overdrive), .rom_id(rom_id), .slot_valid(slot_valid),
    .slot_ready(slot_ready), .slot_bit(slot_bit), .speed_od(speed_od),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 2) == 1;
      default: return ((c * 7 + 3) % 5) > 1;
    endcase
  endfunction

  task automatic run_select(input logic [63:0] id, input logic od, input int mode, input bit inj);
    logic [71:0] rec = '0;
    logic [7:0] cmd = od ? 8'h69 : 8'h55;
    logic prev = spd_model;
    logic spd_bad = 1'b0;
    logic hold_bad = 1'b0;
    logic pend = 1'b0;
    logic held = 1'b0;
    int got = 0;
    int c = 0;
    @(negedge clk);
    start = 1'b1; overdrive = od; rom_id = id;
    @(negedge clk);
    start = 1'b0;
    while (got < 72 && c < 2000) begin
      slot_ready = ready_pat(mode, c);
      if (speed_od !== prev) spd_bad = 1'b1;
      if (pend && (!slot_valid || slot_bit !== held)) hold_bad = 1'b1;
      pend = 1'b0;
      if (slot_valid && slot_ready) begin
        rec[got] = slot_bit;
        got++;
      end else if (slot_valid) begin
        pend = 1'b1;
        held = slot_bit;
      end
      if (inj && got == 20) begin
        start = 1'b1; overdrive = ~od; rom_id = ~id;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    slot_ready = 1'b0;
    start = 1'b0;
    chk("R1 command byte", {56'd0, rec[7:0]}, {56'd0, cmd});
    chk("R2 identifier bits", rec[71:8], id);
    chk("R3 speed steady while busy", {63'd0, spd_bad}, 64'd0);
    chk("R4 request held under back-pressure", {63'd0, hold_bad}, 64'd0);
    if (inj) chk("R5 start ignored while busy", {63'd0, (rec[7:0] == cmd) && (rec[71:8] == id)}, 64'd1);
    chk("R6 done after last slot", {61'd0, done, busy, slot_valid}, {61'd0, 3'b100});
    spd_model = spd_model | od;
    if (od) chk("R7 overdrive after select", {63'd0, speed_od}, {63'd0, spd_model});
    else chk("R8 plain select keeps speed", {63'd0, speed_od}, {63'd0, prev});
    @(negedge clk);
    chk("R6 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    spd_model = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic saw_done;
    repeat (3) @(negedge clk);
    chk("R9 reset state", {60'd0, speed_od, slot_valid, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {60'd0, speed_od, slot_valid, busy, done}, 64'd0);

    for (int i = 0; i < 6; i++) begin
      logic [63:0] id;
      id = (i == 0) ? 64'd0 : (i == 1) ? ~64'd0
           : (64'h0123456789ABCDEF * 64'(i)) ^ (64'd1 << (i * 11));
      for (int o = 0; o < 2; o++) begin
        for (int m = 0; m < 3; m++) begin
          if (((i + m) % 2) == 1) pulse_bus_reset();
          run_select(id, o[0], m, m == 1);
        end
      end
    end

    // R7: overdrive persists through a later plain select (R8)
    pulse_bus_reset();
    run_select(64'hDEADBEEF00C0FFEE, 1'b1, 0, 1'b0);
    run_select(64'h1122334455667788, 1'b0, 2, 1'b0);
    chk("R7 overdrive persists", {63'd0, speed_od}, 64'd1);

    // R9: bus reset returns to standard speed
    pulse_bus_reset();
    chk("R9 bus reset clears speed", {63'd0, speed_od}, 64'd0);

    // R9: bus reset mid-select aborts with no done
    @(negedge clk);
    start = 1'b1; overdrive = 1'b1; rom_id = 64'hA5A5A5A5A5A5A5A5;
    @(negedge clk);
    start = 1'b0; slot_ready = 1'b1;
    repeat (10) @(negedge clk);
    slot_ready = 1'b0;
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    chk("R9 abort clears outputs", {60'd0, speed_od, slot_valid, busy, done}, 64'd0);
    saw_done = 1'b0;
    slot_ready = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (done || slot_valid) saw_done = 1'b1;
    end
    slot_ready = 1'b0;
    chk("R9 aborted select stays silent", {63'd0, saw_done}, 64'd0);

    // R9: asynchronous reset clears overdrive at once
    run_select(64'h0F0F0F0F0F0F0F0F, 1'b1, 1, 1'b0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9 async reset clears speed", {63'd0, speed_od}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    spd_model = 1'b0;
    run_select(64'h8000000000000001, 1'b0, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule